// File: doc/BRIEF.md
# Framed SPI Slave with Per-Transfer Status Bit

This block is a four-wire serial slave. Each transaction is a short frame of bits, not a bare byte shift. The master raises an active-high select and clocks the frame; MOSI, MISO and select are all used on the rising edge of the serial clock. A frame opens with a start bit of 1. Two setup bits follow, a direction bit (1 = read, 0 = write) and an address bit (0 = data, 1 = status). Then come eight data bits, most significant first, and one status bit that the slave drives. The status bit tells the master whether it must retry.

On the local side the slave pops bytes from a transmit buffer and pushes bytes into a receive buffer, both through valid/ready pairs. The serial clock, select and MOSI pass through two-flop synchronizers into the system clock `clk`, and rising edges are detected there. For this reason `clk` must run at least four times faster than the serial clock. Counting the serial rising edges of a frame from 1, the master samples the first data bit at edge 4 and the status bit at edge 12. The slave updates MISO shortly after each rising edge, so a value is ready for the next one.

The frame state machine has five states. `ST_IDLE` waits for a rising edge with select high. On that edge, start = 1 gives the transition to `ST_SETUP`, and start = 0 gives the transition to `ST_HOLD`. `ST_SETUP` takes two edges, one for direction and one for address, and then goes to `ST_DATA`. `ST_DATA` takes eight edges and then goes to `ST_STAT`. `ST_STAT` takes one edge, during which the master samples the status bit, and then goes to `ST_HOLD`. `ST_HOLD` ignores all edges. Select going low sends any state to `ST_IDLE`.

Top module: `spi_status_slave`

## Requirements
- R1: After reset, `spi_miso`, `tx_ready` and `rx_valid` are all low.
- R2: A write frame (start 1, direction 0, address 0, then eight bits MSB first) offers the byte on `rx_data` with `rx_valid` high for one cycle. When `rx_ready` is high in that cycle, the byte is accepted and the status bit is 0. MISO stays low during the write data bits.
- R3: When `rx_ready` is low at the end of a write, the byte is dropped and the status bit is 1.
- R4: A data read (direction 1, address 0) with `tx_valid` high pops exactly one byte, with `tx_ready` high for one cycle. The slave shifts that byte out MSB first, and the master samples it at edges 4 to 11. The status bit at edge 12 is 0.
- R5: A data read with `tx_valid` low pops nothing. It shifts out the last byte sent (0 after reset) and reports status 1.
- R6: A status read (direction 1, address 1) shifts out a byte with bit 0 = `tx_valid`, bit 1 = `rx_ready` and all other bits 0. The status bit is 0, and nothing is popped or pushed.
- R7: A frame whose first bit is 0 is ignored until select goes low: MISO stays low, and nothing is popped or pushed.
- R8: Select going low before the status bit aborts the frame with no push. The next frame is decoded normally.
- R9: After the status bit, further edges with select still high are ignored: no push, no pop, and MISO stays low. A new frame needs select low first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_sel | input | 1 | Active-high slave select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data and status bit to the master |
| tx_valid | input | 1 | Transmit buffer holds a byte |
| tx_data | input | DATA_W | Head byte of the transmit buffer |
| tx_ready | output | 1 | One-cycle pop of the transmit buffer |
| rx_valid | output | 1 | One-cycle offer of a received byte |
| rx_data | output | DATA_W | Received byte |
| rx_ready | input | 1 | Receive buffer has room |

## Verification
The bench sends all 256 write values, so a swapped bit order or an off-by-one in the data bit count shows up as wrong bytes. A read from an empty transmit buffer is checked to repeat the last byte and report status 1; a design that popped anyway, or that shifted out zeros, fails this. Writes into a full receive buffer must report status 1 and leave the stored bytes untouched, which catches a design that still pushes. Three further cases are covered: frames with a 0 start bit, frames cut short by select, and extra edges sent after the status bit. Each checks that nothing is pushed, popped or driven; a state machine that restarted without select going low would push a second byte.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_DATA,
        ST_STAT,
        ST_HOLD
    } sbs_state_e;

    typedef enum logic [1:0] {
        OP_WRITE,
        OP_RDATA,
        OP_RSTAT
    } sbs_op_e;
endpackage

// File: rtl/sbs_sync.sv
module sbs_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/sbs_frame_fsm.sv
module sbs_frame_fsm
    import spi_stat_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              ss_s,
    input  logic              mosi_s,
    output logic              miso,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    input  logic              rx_ready
);
    localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 2;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    sbs_state_e        state, nxt;
    sbs_op_e           op;
    logic [CNT_W-1:0]  cnt;
    logic              rw_q, stat_q, miso_q, sclk_prev;
    logic [DATA_W-1:0] shreg, last_q, status_byte;
    logic              rise;

    assign rise        = sclk_s & ~sclk_prev;
    assign status_byte = {{(DATA_W-2){1'b0}}, rx_ready, tx_valid};
    assign miso        = miso_q;
    assign rx_data     = {shreg[DATA_W-2:0], mosi_s};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        if (!ss_s) begin
            nxt = ST_IDLE;
        end else if (rise) begin
            unique case (state)
                ST_IDLE:  nxt = mosi_s ? ST_SETUP : ST_HOLD;
                ST_SETUP: if (cnt == CNT_W'(1)) nxt = ST_DATA;
                ST_DATA:  if (cnt == LAST) nxt = ST_STAT;
                ST_STAT:  nxt = ST_HOLD;
                ST_HOLD:  nxt = ST_HOLD;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    // buffer handshakes
    always_comb begin
        tx_ready = ss_s && rise && state == ST_SETUP && cnt == CNT_W'(1)
                   && rw_q && !mosi_s;
        rx_valid = ss_s && rise && state == ST_DATA && cnt == LAST
                   && op == OP_WRITE;
    end

    // datapath and serial output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            cnt       <= '0;
            rw_q      <= 1'b0;
            op        <= OP_WRITE;
            shreg     <= '0;
            last_q    <= '0;
            stat_q    <= 1'b0;
            miso_q    <= 1'b0;
        end else begin
            sclk_prev <= sclk_s;
            if (!ss_s) begin
                miso_q <= 1'b0;
                cnt    <= '0;
            end else if (rise) begin
                unique case (state)
                    ST_IDLE: begin
                        cnt    <= '0;
                        miso_q <= 1'b0;
                    end
                    ST_SETUP: begin
                        if (cnt == '0) begin
                            rw_q <= mosi_s;
                            cnt  <= CNT_W'(1);
                        end else begin
                            cnt <= '0;
                            if (!rw_q) begin
                                op     <= OP_WRITE;
                                miso_q <= 1'b0;
                            end else if (mosi_s) begin
                                op     <= OP_RSTAT;
                                shreg  <= status_byte;
                                stat_q <= 1'b0;
                                miso_q <= status_byte[DATA_W-1];
                            end else if (tx_valid) begin
                                op     <= OP_RDATA;
                                shreg  <= tx_data;
                                last_q <= tx_data;
                                stat_q <= 1'b0;
                                miso_q <= tx_data[DATA_W-1];
                            end else begin
                                op     <= OP_RDATA;
                                shreg  <= last_q;
                                stat_q <= 1'b1;
                                miso_q <= last_q[DATA_W-1];
                            end
                        end
                    end
                    ST_DATA: begin
                        cnt <= cnt + 1'b1;
                        if (op == OP_WRITE) begin
                            shreg <= {shreg[DATA_W-2:0], mosi_s};
                            if (cnt == LAST) begin
                                stat_q <= ~rx_ready;
                                miso_q <= ~rx_ready;
                            end
                        end else begin
                            shreg  <= {shreg[DATA_W-2:0], 1'b0};
                            miso_q <= (cnt == LAST) ? stat_q : shreg[DATA_W-2];
                        end
                    end
                    ST_STAT: miso_q <= 1'b0;
                    ST_HOLD: miso_q <= 1'b0;
                    default: miso_q <= 1'b0;
                endcase
            end
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> !miso_q && !rx_valid);
    // R2
    push_then_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> state == ST_STAT && miso_q == !$past(rx_ready));
    // R2
    write_miso_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && op == OP_WRITE) |-> !miso_q);
    // R4
    pop_only_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> state == ST_SETUP && rw_q && !rx_valid);
    // R6
    status_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STAT && op == OP_RSTAT) |-> !miso_q);
    // R8
    abort_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_s |=> state == ST_IDLE);
    // R9
    hold_until_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && ss_s) |=> state == ST_HOLD && !miso_q);
endmodule

// File: rtl/spi_status_slave.sv
module spi_status_slave #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_sel,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    input  logic              rx_ready
);
    localparam int NSIG = 3;

    logic [NSIG-1:0] pins_s;

    sbs_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({spi_sclk, spi_sel, spi_mosi}),
        .dout (pins_s)
    );

    sbs_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (pins_s[2]),
        .ss_s    (pins_s[1]),
        .mosi_s  (pins_s[0]),
        .miso    (spi_miso),
        .tx_valid(tx_valid),
        .tx_data (tx_data),
        .tx_ready(tx_ready),
        .rx_valid(rx_valid),
        .rx_data (rx_data),
        .rx_ready(rx_ready)
    );
endmodule

// File: tb/tb_spi_status_slave.sv
`timescale 1ns/1ps
module tb_spi_status_slave;
    localparam int HALF = 8;   // clk cycles per serial half period
    localparam int RXCAP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sel = 1'b0, mosi = 1'b0;
    logic miso, tx_ready, rx_valid, tx_valid, rx_ready;
    logic [7:0] tx_data, rx_data;

    always #10 clk = ~clk;

    // buffer models: tail/rd owned by the stimulus, head/wr by the model
    logic [7:0] txq [16];
    logic [7:0] rxq [RXCAP];
    int tx_tail = 0, tx_head = 0, pops = 0;
    int rx_wr = 0, rx_rd = 0;
    int total = 0, bad = 0;

    assign tx_valid = (tx_tail != tx_head);
    assign tx_data  = txq[tx_head % 16];
    assign rx_ready = (rx_wr - rx_rd) < RXCAP;

    always @(posedge clk) begin
        if (tx_valid && tx_ready) begin
            tx_head <= tx_head + 1;
            pops    <= pops + 1;
        end
        if (rx_valid && rx_ready) begin
            rxq[rx_wr % RXCAP] <= rx_data;
            rx_wr <= rx_wr + 1;
        end
    end

    spi_status_slave dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_sel(sel),
        .spi_mosi(mosi), .spi_miso(miso), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_ready(rx_ready)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clock_bit(input logic m, output logic s);
        sclk = 1'b0;
        mosi = m;
        wait_clk(HALF);
        s = miso;
        sclk = 1'b1;
        wait_clk(HALF);
    endtask

    // nbits < 12 cuts the frame; extra > 0 keeps select high for more edges
    task automatic frame(input logic st, input logic rw, input logic ad,
                         input logic [7:0] wb, input int nbits, input int extra,
                         output logic [7:0] rb, output logic sb,
                         output logic any_hi, output logic extra_hi);
        logic [11:0] bits;
        logic s;
        bits = {st, rw, ad, wb, 1'b0};
        rb = '0; sb = 1'b0; any_hi = 1'b0; extra_hi = 1'b0;
        wait_clk(2);
        sel = 1'b1;
        wait_clk(4);
        for (int i = 0; i < nbits; i++) begin
            clock_bit(bits[11-i], s);
            any_hi = any_hi | s;
            if (i >= 3 && i <= 10) rb[10-i] = s;
            if (i == 11) sb = s;
        end
        for (int i = 0; i < extra; i++) begin
            clock_bit(bits[11 - (i % 12)], s);
            extra_hi = extra_hi | s;
        end
        sclk = 1'b0;
        mosi = 1'b0;
        wait_clk(HALF);
        sel = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic drain_rx();
        rx_rd = rx_wr;
    endtask

    initial begin
        logic [7:0] rb, last;
        logic sb, hi, xhi;
        int p0, w0;

        wait_clk(5);
        // R1 reset state
        check("R1 miso", miso, 0);
        check("R1 tx_ready", tx_ready, 0);
        check("R1 rx_valid", rx_valid, 0);
        rst_n = 1'b1;
        wait_clk(4);

        // R6 status read, tx empty, rx has room
        frame(1, 1, 1, 8'h00, 12, 0, rb, sb, hi, xhi);
        check("R6 status byte empty", rb, 8'h02);
        check("R6 status bit", sb, 0);

        // R5 read from empty tx after reset
        p0 = pops;
        frame(1, 1, 0, 8'h00, 12, 0, rb, sb, hi, xhi);
        check("R5 byte after reset", rb, 8'h00);
        check("R5 status", sb, 1);
        check("R5 no pop", pops - p0, 0);

        // R2 sweep every write value
        for (int b = 0; b < 256; b++) begin
            w0 = rx_wr;
            frame(1, 0, 0, 8'(b), 12, 0, rb, sb, hi, xhi);
            check("R2 write status", sb, 0);
            check("R2 one push", rx_wr - w0, 1);
            check("R2 byte", rxq[(rx_wr - 1) % RXCAP], b);
            check("R2 miso low in data", rb, 8'h00);
            drain_rx();
        end

        // R3 fill rx buffer, then overflow
        for (int k = 0; k < RXCAP; k++)
            frame(1, 0, 0, 8'(8'hA0 + k), 12, 0, rb, sb, hi, xhi);
        w0 = rx_wr;
        frame(1, 0, 0, 8'h5A, 12, 0, rb, sb, hi, xhi);
        check("R3 full status", sb, 1);
        check("R3 no push", rx_wr - w0, 0);
        check("R3 contents kept", rxq[(rx_wr - 1) % RXCAP], 8'hA3);
        frame(1, 1, 1, 8'h00, 12, 0, rb, sb, hi, xhi);
        check("R6 status byte full", rb, 8'h00);
        drain_rx();

        // R4 reads of a queued sequence
        for (int k = 0; k < 8; k++) begin
            txq[tx_tail % 16] = 8'((k * 37 + 5) & 8'hFF);
            tx_tail++;
        end
        frame(1, 1, 1, 8'h00, 12, 0, rb, sb, hi, xhi);
        check("R6 status byte both", rb, 8'h03);
        check("R6 no pop", pops, 0);
        for (int k = 0; k < 8; k++) begin
            p0 = pops;
            frame(1, 1, 0, 8'h00, 12, 0, rb, sb, hi, xhi);
            check("R4 read byte", rb, (k * 37 + 5) & 8'hFF);
            check("R4 status", sb, 0);
            check("R4 one pop", pops - p0, 1);
        end
        last = 8'((7 * 37 + 5) & 8'hFF);

        // R5 empty again: repeat last byte
        p0 = pops;
        frame(1, 1, 0, 8'h00, 12, 0, rb, sb, hi, xhi);
        check("R5 repeat last", rb, last);
        check("R5 stale status", sb, 1);
        check("R5 no pop", pops - p0, 0);

        // R7 start bit 0 ignored
        txq[tx_tail % 16] = 8'hC3;
        tx_tail++;
        p0 = pops; w0 = rx_wr;
        frame(0, 1, 0, 8'hFF, 12, 0, rb, sb, hi, xhi);
        check("R7 miso low", hi, 0);
        check("R7 no pop", pops - p0, 0);
        check("R7 no push", rx_wr - w0, 0);
        frame(1, 1, 0, 8'h00, 12, 0, rb, sb, hi, xhi);
        check("R7 byte still queued", rb, 8'hC3);

        // R8 abort mid write, then a normal write
        w0 = rx_wr;
        frame(1, 0, 0, 8'h77, 7, 0, rb, sb, hi, xhi);
        check("R8 no push on abort", rx_wr - w0, 0);
        frame(1, 0, 0, 8'h3C, 12, 0, rb, sb, hi, xhi);
        check("R8 next frame push", rx_wr - w0, 1);
        check("R8 next frame byte", rxq[(rx_wr - 1) % RXCAP], 8'h3C);
        drain_rx();

        // R9 extra edges with select held high
        w0 = rx_wr;
        frame(1, 0, 0, 8'h81, 12, 12, rb, sb, hi, xhi);
        check("R9 single push", rx_wr - w0, 1);
        check("R9 miso low after status", xhi, 0);
        check("R9 byte", rxq[(rx_wr - 1) % RXCAP], 8'h81);
        drain_rx();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule